// File: doc/BRIEF.md
# Scan Chain Broadcast Expander

This block lets one test pattern generator fill four times as many scan chains as it drives directly. Each incoming chain bit is copied onto four output lanes, three of them inverted or not according to a 2-bit mask. The same mask applies to every bit shifted in for one pattern, so one source stream becomes four related streams that differ by a per-pattern flip.

The mask comes from a tiny 2-bit linear feedback register with a cycle of three nonzero states. It moves one step only when the pattern-advance strobe is high, and it holds between strobes. Incoming chains are handled in pairs. The lead (even-numbered) chain and the trail (odd-numbered) chain of a pair spread their four flip choices across their lanes in different orders. When the chain count is odd, the last chain uses the lead order. All lane outputs are registered, so each one appears one clock after the bit that produced it.

Top module: `scan_bcast_expander`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `bcast_out` is 0 after that edge, and the mask returns to state 2'b01.
- R2: Each output bit is registered. The value seen after rising edge k+1 comes from `chain_in` and the mask state in effect during the cycle before edge k+1.
- R3: Lead chain k (k even) drives `bcast_out[4k+0..4k+3]` with C^B1, C^B0^B1, C and C^B0, where C = `chain_in[k]`, B0 = mask bit 0 and B1 = mask bit 1.
- R4: Trail chain k (k odd) drives `bcast_out[4k+0..4k+3]` with D^B0, D, D^B0^B1 and D^B1, where D = `chain_in[k]`.
- R5: The mask state visits 2'b01, 2'b11, 2'b10 and then 2'b01 again. It takes one step at each rising edge where `pat_adv` is high, holds when `pat_adv` is low, and never reaches 2'b00.
- R6: When `pat_adv` and a data bit are sampled at the same edge, that bit is flipped with the mask state from before the step.
- R7: One lane of every chain carries the chain bit unflipped whatever the mask: lane 2 for a lead chain and lane 1 for a trail chain.
- R8: With an odd chain count, the last chain uses the lead ordering of R3.
- R9: A reset that arrives in the middle of a run restarts the mask at 2'b01, whatever state it had reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_adv | input | 1 | Pattern-advance strobe; steps the mask |
| chain_in | input | NUM_CHAINS | One scan-in bit for each original chain |
| bcast_out | output | 4*NUM_CHAINS | Registered broadcast lanes; chain k occupies bits 4k..4k+3 |

## Verification
Every lane result is due exactly one rising edge after the inputs that produced it. A strobe changes only the mask used for bits sampled at later edges. The driver sets the inputs just after a falling edge and pushes the expected lane vector into a queue. The monitor pops that entry just after the next rising edge, so each comparison falls on the cycle where the register has captured that stimulus. A second instance with three chains runs the same stream, which covers the odd-count rule. Strobes are placed both together with data changes and apart from them, so that the pre-step mask rule of R6 and the hold rule of R5 are both checked.

// File: rtl/bcast_pkg.sv
package bcast_pkg;

  // Mask state: bit 0 is B0, bit 1 is B1.
  typedef logic [1:0] mask_t;

  localparam mask_t MASK_RESET = 2'b01;

  // Lane ordering variants for chains within a pair.
  typedef enum logic {
    ORDER_LEAD  = 1'b0,
    ORDER_TRAIL = 1'b1
  } order_e;

  // One step of the 2-bit maximal-length register: 01 -> 11 -> 10 -> 01.
  function automatic mask_t mask_step(input mask_t s);
    return {s[0], s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/bcast_mask_lfsr.sv
module bcast_mask_lfsr
  import bcast_pkg::*;
#(
  parameter mask_t SEED = MASK_RESET
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output mask_t mask_o
);

  mask_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (adv) begin
      state_q <= mask_step(state_q);
    end
  end

  assign mask_o = state_q;

endmodule

// File: rtl/bcast_chain_fanout.sv
module bcast_chain_fanout
  import bcast_pkg::*;
#(
  parameter order_e ORDER = ORDER_LEAD
) (
  input  logic       chain_bit,
  input  mask_t      mask,
  output logic [3:0] lanes
);

  logic b0;
  logic b1;
  logic b01;

  assign b0  = mask[0];
  assign b1  = mask[1];
  assign b01 = mask[0] ^ mask[1];

  generate
    if (ORDER == ORDER_LEAD) begin : g_lead
      assign lanes[0] = chain_bit ^ b1;
      assign lanes[1] = chain_bit ^ b01;
      assign lanes[2] = chain_bit;
      assign lanes[3] = chain_bit ^ b0;
    end else begin : g_trail
      assign lanes[0] = chain_bit ^ b0;
      assign lanes[1] = chain_bit;
      assign lanes[2] = chain_bit ^ b01;
      assign lanes[3] = chain_bit ^ b1;
    end
  endgenerate

endmodule

// File: rtl/bcast_out_reg.sv
module bcast_out_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/scan_bcast_expander.sv
module scan_bcast_expander
  import bcast_pkg::*;
#(
  parameter int NUM_CHAINS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pat_adv,
  input  logic [NUM_CHAINS-1:0]   chain_in,
  output logic [4*NUM_CHAINS-1:0] bcast_out
);

  localparam int LANES_PER_CHAIN = 4;
  localparam int OUT_W           = LANES_PER_CHAIN * NUM_CHAINS;

  mask_t            mask_q;
  logic [OUT_W-1:0] lanes_d;

  bcast_mask_lfsr #(
    .SEED (MASK_RESET)
  ) u_mask (
    .clk    (clk),
    .rst    (rst),
    .adv    (pat_adv),
    .mask_o (mask_q)
  );

  // Even chains lead a pair; odd chains trail. A lone last chain is even.
  generate
    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
      localparam order_e ORD = (k % 2 == 0) ? ORDER_LEAD : ORDER_TRAIL;
      bcast_chain_fanout #(
        .ORDER (ORD)
      ) u_fan (
        .chain_bit (chain_in[k]),
        .mask      (mask_q),
        .lanes     (lanes_d[LANES_PER_CHAIN*k +: LANES_PER_CHAIN])
      );
    end
  endgenerate

  bcast_out_reg #(
    .WIDTH (OUT_W)
  ) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (lanes_d),
    .q   (bcast_out)
  );

endmodule

// File: rtl/scan_bcast_expander_chk.sv
module scan_bcast_expander_chk #(
  parameter int NUM_CHAINS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pat_adv,
  input logic [NUM_CHAINS-1:0]   chain_in,
  input logic [4*NUM_CHAINS-1:0] bcast_out,
  input logic [1:0]              mask_state
);

  logic live_q;

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  // R1: output is cleared after a reset edge
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bcast_out == '0));

  // R5: mask never reaches the all-zero state
  a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (mask_state != 2'b00));

  // R5: mask holds without a strobe
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(rst) && !$past(pat_adv)) |-> $stable(mask_state));

  // R5: mask moves on a strobe
  a_r5_mask_moves: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(rst) && $past(pat_adv)) |-> (mask_state != $past(mask_state)));

  generate
    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chk
      localparam int PLAIN = (k % 2 == 0) ? 2 : 1;
      // R7 / R2: unflipped lane equals the chain bit one edge earlier
      a_r7_plain_lane: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(rst)) |-> (bcast_out[4*k+PLAIN] == $past(chain_in[k])));
      // R3 / R4: lane pairs carry the same combined flip in both orderings
      a_r3_mask_consistent: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(rst)) |->
          ((bcast_out[4*k] ^ bcast_out[4*k+3]) == (bcast_out[4*k+1] ^ bcast_out[4*k+2])));
    end
  endgenerate

endmodule

bind scan_bcast_expander scan_bcast_expander_chk #(
  .NUM_CHAINS (NUM_CHAINS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pat_adv    (pat_adv),
  .chain_in   (chain_in),
  .bcast_out  (bcast_out),
  .mask_state (mask_q)
);

// File: tb/scan_bcast_expander_tb.sv
module scan_bcast_expander_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC_EVEN    = 4;
  localparam int NC_ODD     = 3;

  typedef struct {
    logic [4*NC_EVEN-1:0] exp_even;
    logic [4*NC_ODD-1:0]  exp_odd;
    string                tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pat_adv = 1'b0;
  logic [NC_EVEN-1:0]   chain_in = '0;
  logic [4*NC_EVEN-1:0] out_even;
  logic [4*NC_ODD-1:0]  out_odd;

  int checks = 0;
  int errors = 0;
  item_t sb_q[$];
  logic [1:0] model_mask = 2'b01;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_bcast_expander #(.NUM_CHAINS(NC_EVEN)) u_dut (
    .clk(clk), .rst(rst), .pat_adv(pat_adv),
    .chain_in(chain_in), .bcast_out(out_even));

  scan_bcast_expander #(.NUM_CHAINS(NC_ODD)) u_dut_odd (
    .clk(clk), .rst(rst), .pat_adv(pat_adv),
    .chain_in(chain_in[NC_ODD-1:0]), .bcast_out(out_odd));

  // Expected lanes for one chain (R3 lead order, R4 trail order).
  function automatic logic [3:0] lanes_of(input logic c, input logic [1:0] m, input bit lead);
    logic b0, b1;
    b0 = m[0];
    b1 = m[1];
    if (lead) return {c ^ b0, c, c ^ b0 ^ b1, c ^ b1};
    else      return {c ^ b1, c ^ b0 ^ b1, c, c ^ b0};
  endfunction

  // R5 sequence 01 -> 11 -> 10 -> 01
  function automatic logic [1:0] model_next(input logic [1:0] m);
    case (m)
      2'b01:   return 2'b11;
      2'b11:   return 2'b10;
      2'b10:   return 2'b01;
      default: return 2'b01;
    endcase
  endfunction

  task automatic drive(input logic r, input logic a, input logic [NC_EVEN-1:0] c, input string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    pat_adv = a;
    chain_in = c;
    it.tag = tag;
    it.exp_even = '0;
    it.exp_odd = '0;
    if (!r) begin
      for (int k = 0; k < NC_EVEN; k++)
        it.exp_even[4*k +: 4] = lanes_of(c[k], model_mask, (k % 2) == 0);
      // R8: last chain of the odd instance is even-indexed, lead order
      for (int k = 0; k < NC_ODD; k++)
        it.exp_odd[4*k +: 4] = lanes_of(c[k], model_mask, (k % 2) == 0);
    end
    sb_q.push_back(it);
    if (r)      model_mask = 2'b01;
    else if (a) model_mask = model_next(model_mask);
  endtask

  // Monitor: result is due one rising edge after the driven inputs (R2).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (out_even !== it.exp_even) begin
          errors++;
          $display("FAIL %s even: actual %h expected %h", it.tag, out_even, it.exp_even);
        end
        checks++;
        if (out_odd !== it.exp_odd) begin
          errors++;
          $display("FAIL %s odd: actual %h expected %h", it.tag, out_odd, it.exp_odd);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive(1, 0, 4'b1111, "R1");
    drive(1, 1, 4'b1010, "R1");
    // Initial mask 01: B0=1, B1=0
    drive(0, 0, 4'b0000, "R3");
    drive(0, 0, 4'b1111, "R4");
    drive(0, 0, 4'b0101, "R7");
    drive(0, 0, 4'b1010, "R2");
    // R6: strobe together with data uses the pre-step mask
    drive(0, 1, 4'b0110, "R6");
    drive(0, 0, 4'b0110, "R5");
    drive(0, 0, 4'b1001, "R5");
    drive(0, 1, 4'b1100, "R6");
    drive(0, 0, 4'b0011, "R3");
    drive(0, 1, 4'b1111, "R4");
    drive(0, 0, 4'b0101, "R5");
    // R5 hold over many cycles
    for (int i = 0; i < 10; i++) drive(0, 0, 4'(i * 5 + 3), "R5");
    // Mixed stream, strobe every third pattern
    for (int i = 0; i < 30; i++) drive(0, (i % 3) == 0, 4'(i * 7 + 1), "R8");
    // R9: mid-run reset restarts the mask
    drive(0, 1, 4'b1111, "R9");
    drive(1, 0, 4'b1111, "R9");
    drive(0, 0, 4'b1111, "R9");
    drive(0, 0, 4'b0101, "R9");
    drive(0, 1, 4'b0000, "R7");
    drive(0, 0, 4'b1111, "R3");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule